// File: doc/BRIEF.md
# Eight-Bit Accumulator Processor Core

This block is a very small 8-bit processor built around a single accumulator. It reads one instruction byte per cycle from an external program memory. It keeps eight general data registers in a small register file, and routes every arithmetic result through the accumulator. A single carry flag is the only condition it can test. That flag comes from the carry-out of an addition, so one add both advances a loop variable and tells the program whether the loop should continue.

Most instructions are one byte long and complete in one cycle. The long conditional branch and the unconditional jump take a second byte that holds an absolute target address, so they complete in two cycles. A registered output port shows the accumulator each time the output instruction runs, with a valid strobe that lasts one cycle. A retired-instruction counter is brought out so that a bench can measure how long a program runs.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is high at a clock edge, the next state has pmem_addr = 0, out_valid = 0, instr_count = 0, the accumulator at 0 and carry clear. After reset is released, the first instruction fetched is at address 0.
- R2: Opcode 00iiiiii loads the accumulator with the 6-bit field iiiiii, sign-extended to 8 bits. 0x3F loads 0xFF and 0x20 loads 0xE0.
- R3: Opcode 0x48|r copies the accumulator into register r, and opcode 0x40|r copies register r into the accumulator (r = 0..7). The eight registers hold their values independently.
- R4: Opcode 0x50|r adds register r to the accumulator and sets carry to the unsigned carry-out of bit 7. Load, store, negate and output instructions leave carry unchanged.
- R5: Opcode 0x58 replaces the accumulator with its two's complement.
- R6: Opcode 0x59 makes out_valid high for exactly the one cycle after the edge that executes it, with out_data equal to the accumulator at that edge. Each such instruction gives one strobe.
- R7: Opcode 1sssssss is a short conditional branch. With carry clear, the next address is the branch's own address plus the sign-extended 7-bit field. With carry set, execution falls through to the next address. Either way carry is clear afterwards, so 0x80 with carry clear loops on itself.
- R8: Opcode 0x5A is followed by a target byte. With carry clear it continues at that absolute target. With carry set it continues two bytes after the opcode. Either way carry is clear afterwards.
- R9: Opcode 0x5B is followed by a target byte and always continues at that absolute target.
- R10: Opcodes 0x5C to 0x7F do nothing except advance the address by one. The accumulator and carry are left unchanged.
- R11: instr_count rises by one for each completed instruction. A one-byte instruction completes in one cycle and a two-byte instruction in two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pmem_addr | output | PC_W | Address of the program byte being read |
| pmem_data | input | 8 | Program byte at pmem_addr, valid in the same cycle |
| out_data | output | DATA_W | Accumulator value captured by the output instruction |
| out_valid | output | 1 | One-cycle strobe marking a new out_data |
| instr_count | output | CNT_W | Number of instructions completed since reset |

## Verification
Most internal faults in this core appear first as a wrong address on pmem_addr at the next edge. A bad branch decision, a branch that misreads the carry flag, or a mishandled second byte all do this, so the bench follows program flow through the output values a program chooses to show. A wrong accumulator or register value stays hidden until an output instruction copies it out one edge later. The directed programs therefore place an output instruction right after each operation under test. A carry flag left set or clear by mistake shows only when the next conditional branch goes the wrong way. For that reason the carry tests chain several branches and compare the sequence of values that comes out.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int INSN_W = 8;
  localparam int IMM_W  = 6;
  localparam int REL_W  = 7;
  localparam int RSEL_W = 3;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_LDI,
    OP_LDA,
    OP_STA,
    OP_ADD,
    OP_NEG,
    OP_OUT,
    OP_BCC,
    OP_BCCL,
    OP_JMP
  } op_e;

  typedef enum logic {
    PH_OPCODE,
    PH_TARGET
  } phase_e;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] rsel;
    logic [IMM_W-1:0]  imm;
    logic [REL_W-1:0]  rel;
    logic              two_byte;
  } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);

  always_comb begin
    dec.op   = OP_NOP;
    dec.rsel = insn[RSEL_W-1:0];
    dec.imm  = insn[IMM_W-1:0];
    dec.rel  = insn[REL_W-1:0];
    if (insn[7]) begin
      dec.op = OP_BCC;
    end else if (!insn[6]) begin
      dec.op = OP_LDI;
    end else if (!insn[5]) begin
      unique case (insn[4:3])
        2'd0: dec.op = OP_LDA;
        2'd1: dec.op = OP_STA;
        2'd2: dec.op = OP_ADD;
        default: begin
          unique case (insn[2:0])
            3'd0:    dec.op = OP_NEG;
            3'd1:    dec.op = OP_OUT;
            3'd2:    dec.op = OP_BCCL;
            3'd3:    dec.op = OP_JMP;
            default: dec.op = OP_NOP;
          endcase
        end
      endcase
    end
    dec.two_byte = (dec.op == OP_BCCL) || (dec.op == OP_JMP);
  end

endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] res,
  output logic              acc_we,
  output logic              carry_we,
  output logic              carry_nx
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] imm_ext;

  assign sum     = {1'b0, acc} + {1'b0, opnd};
  assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};

  always_comb begin
    res      = acc;
    acc_we   = 1'b0;
    carry_we = 1'b0;
    carry_nx = 1'b0;
    unique case (op)
      OP_LDI: begin
        res    = imm_ext;
        acc_we = 1'b1;
      end
      OP_LDA: begin
        res    = opnd;
        acc_we = 1'b1;
      end
      OP_ADD: begin
        res      = sum[DATA_W-1:0];
        acc_we   = 1'b1;
        carry_we = 1'b1;
        carry_nx = sum[DATA_W];
      end
      OP_NEG: begin
        res    = ~acc + ONE;
        acc_we = 1'b1;
      end
      OP_BCC: begin
        carry_we = 1'b1;
        carry_nx = 1'b0;
      end
      default: begin
        res = acc;
      end
    endcase
  end

endmodule

// File: rtl/acc_cpu_pcunit.sv
module acc_cpu_pcunit
  import acc_cpu_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  phase_e            phase,
  input  logic              is_bcc,
  input  logic              two_byte,
  input  logic [REL_W-1:0]  rel,
  input  logic              carry,
  input  logic              pend_jmp,
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] bus,
  output logic [PC_W-1:0]   pc_nx,
  output phase_e            phase_nx
);

  localparam logic [PC_W-1:0] PC_ONE = PC_W'(1);

  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] rel_ext;

  generate
    if (PC_W > INSN_W) begin : g_tgt_wide
      assign tgt = {{(PC_W-INSN_W){1'b0}}, bus};
    end else if (PC_W == INSN_W) begin : g_tgt_same
      assign tgt = bus;
    end else begin : g_tgt_narrow
      assign tgt = bus[PC_W-1:0];
    end

    if (PC_W > REL_W) begin : g_rel_wide
      assign rel_ext = {{(PC_W-REL_W){rel[REL_W-1]}}, rel};
    end else begin : g_rel_narrow
      assign rel_ext = rel[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    pc_nx    = pc + PC_ONE;
    phase_nx = PH_OPCODE;
    if (phase == PH_OPCODE) begin
      if (is_bcc && !carry) begin
        pc_nx = pc + rel_ext;
      end
      if (two_byte) begin
        phase_nx = PH_TARGET;
      end
    end else begin
      if (pend_jmp || !carry) begin
        pc_nx = tgt;
      end
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   pmem_addr,
  input  logic [INSN_W-1:0] pmem_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic [CNT_W-1:0]  instr_count
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e            phase_q;
  phase_e            phase_nx;
  logic              fetch_phase;
  dec_t              dec;
  logic [PC_W-1:0]   pc_q;
  logic [PC_W-1:0]   pc_nx;
  logic              pend_jmp_q;
  logic [DATA_W-1:0] acc_q;
  logic              carry_q;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_we;
  logic [DATA_W-1:0] alu_res;
  logic              alu_acc_we;
  logic              alu_carry_we;
  logic              alu_carry_nx;
  logic              retire;
  logic              do_out;
  logic [DATA_W-1:0] out_data_q;
  logic              out_valid_q;
  logic [CNT_W-1:0]  count_q;

  assign fetch_phase = (phase_q == PH_OPCODE);

  acc_cpu_decode u_decode (
    .insn (pmem_data),
    .dec  (dec)
  );

  assign rf_we = fetch_phase && (dec.op == OP_STA);

  acc_cpu_regfile #(
    .DATA_W (DATA_W),
    .ADDR_W (RSEL_W)
  ) u_regfile (
    .clk   (clk),
    .we    (rf_we),
    .waddr (dec.rsel),
    .wdata (acc_q),
    .raddr (dec.rsel),
    .rdata (rf_rdata)
  );

  acc_cpu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op       (dec.op),
    .acc      (acc_q),
    .opnd     (rf_rdata),
    .imm      (dec.imm),
    .res      (alu_res),
    .acc_we   (alu_acc_we),
    .carry_we (alu_carry_we),
    .carry_nx (alu_carry_nx)
  );

  acc_cpu_pcunit #(
    .PC_W (PC_W)
  ) u_pcunit (
    .phase    (phase_q),
    .is_bcc   (dec.op == OP_BCC),
    .two_byte (dec.two_byte),
    .rel      (dec.rel),
    .carry    (carry_q),
    .pend_jmp (pend_jmp_q),
    .pc       (pc_q),
    .bus      (pmem_data),
    .pc_nx    (pc_nx),
    .phase_nx (phase_nx)
  );

  assign retire = fetch_phase ? !dec.two_byte : 1'b1;
  assign do_out = fetch_phase && (dec.op == OP_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q        <= '0;
      phase_q     <= PH_OPCODE;
      pend_jmp_q  <= 1'b0;
      acc_q       <= '0;
      carry_q     <= 1'b0;
      out_data_q  <= '0;
      out_valid_q <= 1'b0;
      count_q     <= '0;
    end else begin
      pc_q        <= pc_nx;
      phase_q     <= phase_nx;
      out_valid_q <= do_out;
      if (do_out) begin
        out_data_q <= acc_q;
      end
      if (retire) begin
        count_q <= count_q + CNT_ONE;
      end
      if (fetch_phase) begin
        if (alu_acc_we) begin
          acc_q <= alu_res;
        end
        if (alu_carry_we) begin
          carry_q <= alu_carry_nx;
        end
        if (dec.two_byte) begin
          pend_jmp_q <= (dec.op == OP_JMP);
        end
      end else if (!pend_jmp_q) begin
        carry_q <= 1'b0;
      end
    end
  end

  assign pmem_addr   = pc_q;
  assign out_data    = out_data_q;
  assign out_valid   = out_valid_q;
  assign instr_count = count_q;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [PC_W-1:0]   pmem_addr,
  input logic [7:0]        pmem_data,
  input logic [DATA_W-1:0] out_data,
  input logic              out_valid,
  input logic [CNT_W-1:0]  instr_count,
  input logic              fetch_phase,
  input logic              carry,
  input logic [DATA_W-1:0] acc
);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (pmem_addr == '0 && !out_valid && instr_count == '0 && !carry && acc == '0));

  assert_count_step_R11: assert property (@(posedge clk) disable iff (rst)
    (instr_count == $past(instr_count)) || (instr_count == $past(instr_count) + CNT_W'(1)));

  assert_out_value_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data == $past(acc)));

  assert_neg_value_R5: assert property (@(posedge clk) disable iff (rst)
    (fetch_phase && pmem_data == 8'h58) |=> (acc == DATA_W'(~$past(acc) + DATA_W'(1))));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_phase && pmem_data == 8'h80 && !carry) |=> (pmem_addr == $past(pmem_addr)));

  assert_branch_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (fetch_phase && pmem_data[7]) |=> !carry);

  assert_two_byte_R8: assert property (@(posedge clk) disable iff (rst)
    (fetch_phase && (pmem_data == 8'h5A || pmem_data == 8'h5B)) |=> !fetch_phase);

  assert_undef_nop_R10: assert property (@(posedge clk) disable iff (rst)
    (fetch_phase && pmem_data[7:5] == 3'b011)
      |=> (pmem_addr == PC_W'($past(pmem_addr) + PC_W'(1)) && acc == $past(acc)
           && carry == $past(carry)));

endmodule

bind acc_cpu_core acc_cpu_checker #(
  .DATA_W (DATA_W),
  .PC_W   (PC_W),
  .CNT_W  (CNT_W)
) u_acc_cpu_checker (
  .clk         (clk),
  .rst         (rst),
  .pmem_addr   (pmem_addr),
  .pmem_data   (pmem_data),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .instr_count (instr_count),
  .fetch_phase (fetch_phase),
  .carry       (carry_q),
  .acc         (acc_q)
);

// File: tb/test_acc_cpu_core.sv
`timescale 1ns/1ps
module test_acc_cpu_core;

  logic        clk;
  logic        rst;
  logic [7:0]  pmem_addr;
  logic [7:0]  pmem_data;
  logic [7:0]  out_data;
  logic        out_valid;
  logic [31:0] instr_count;

  logic [7:0] rom [256];
  logic [7:0] cap [64];
  int         ncap;
  int         checks;
  int         failures;

  acc_cpu_core i_acc_cpu_core (
    .clk         (clk),
    .rst         (rst),
    .pmem_addr   (pmem_addr),
    .pmem_data   (pmem_data),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .instr_count (instr_count)
  );

  assign pmem_data = rom[pmem_addr];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst && out_valid && ncap < 64) begin
      cap[ncap] = out_data;
      ncap = ncap + 1;
    end
  end

  function automatic logic [7:0] a_ldi(int v);  return {2'b00, 6'(v)};        endfunction
  function automatic logic [7:0] a_lda(int r);  return 8'h40 | 8'(r & 7);     endfunction
  function automatic logic [7:0] a_sta(int r);  return 8'h48 | 8'(r & 7);     endfunction
  function automatic logic [7:0] a_add(int r);  return 8'h50 | 8'(r & 7);     endfunction
  function automatic logic [7:0] a_bcc(int o);  return {1'b1, 7'(o)};         endfunction
  localparam logic [7:0] A_NEG = 8'h58, A_OUT = 8'h59, A_BCCL = 8'h5A, A_JMP = 8'h5B;

  task automatic check_eq(string req, string what, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h80;
  endtask

  task automatic start_run(int cycles);
    rst  = 1'b1;
    ncap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic check_caps(string req, int exp[]);
    check_eq(req, "output count", ncap, exp.size());
    for (int i = 0; i < exp.size() && i < ncap; i++)
      check_eq(req, $sformatf("output %0d", i), int'(cap[i]), exp[i]);
  endtask

  task automatic t_reset();
    clear_rom();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1", "pmem_addr in reset", int'(pmem_addr), 0);
    check_eq("R1", "out_valid in reset", int'(out_valid), 0);
    check_eq("R1", "instr_count in reset", int'(instr_count), 0);
  endtask

  task automatic t_ldi_out();
    clear_rom();
    rom[0] = a_ldi(-1); rom[1] = A_OUT;
    rom[2] = a_ldi(31); rom[3] = A_OUT;
    rom[4] = a_ldi(-32); rom[5] = A_OUT; rom[6] = A_OUT;
    start_run(12);
    check_caps("R2", '{255, 31, 224, 224});
  endtask

  task automatic t_regs();
    clear_rom();
    for (int k = 0; k < 8; k++) begin
      rom[2*k]   = a_ldi(3*k + 1);
      rom[2*k+1] = a_sta(k);
    end
    for (int k = 0; k < 8; k++) begin
      rom[16 + 2*k]     = a_lda(7 - k);
      rom[16 + 2*k + 1] = A_OUT;
    end
    start_run(40);
    check_caps("R3", '{22, 19, 16, 13, 10, 7, 4, 1});
  endtask

  task automatic t_add_carry();
    clear_rom();
    rom[0]  = a_ldi(-1); rom[1] = a_sta(7); rom[2] = a_ldi(0);
    rom[3]  = a_add(7);  rom[4] = a_bcc(2); rom[5] = a_ldi(5); rom[6] = A_OUT;
    rom[7]  = a_ldi(1);  rom[8] = a_add(7); rom[9] = a_bcc(2); rom[10] = a_ldi(9);
    rom[11] = A_OUT;     rom[12] = a_bcc(2); rom[13] = a_ldi(7); rom[14] = A_OUT;
    rom[15] = a_ldi(3);  rom[16] = a_sta(0); rom[17] = a_ldi(1); rom[18] = a_add(7);
    rom[19] = A_NEG;     rom[20] = a_lda(0); rom[21] = a_sta(1); rom[22] = A_OUT;
    rom[23] = a_bcc(2);  rom[24] = a_ldi(4); rom[25] = A_OUT;
    start_run(40);
    // R4 0+0xFF no carry; R7 not-taken clears carry; R4 carry kept across NEG/LDA/STA/OUT
    check_caps("R4", '{255, 9, 9, 3, 4});
  endtask

  task automatic t_neg();
    clear_rom();
    rom[0] = a_ldi(5);   rom[1] = A_NEG; rom[2] = A_OUT;
    rom[3] = a_ldi(0);   rom[4] = A_NEG; rom[5] = A_OUT;
    rom[6] = a_ldi(-32); rom[7] = A_NEG; rom[8] = A_OUT;
    start_run(16);
    check_caps("R5", '{251, 0, 32});
  endtask

  task automatic t_jmp();
    clear_rom();
    rom[0] = a_ldi(2); rom[1] = A_JMP; rom[2] = 8'hC0;
    rom[3] = a_ldi(1); rom[4] = A_OUT;
    rom[8'hC0] = A_OUT; rom[8'hC1] = A_JMP; rom[8'hC2] = 8'h05;
    rom[5] = a_ldi(6); rom[6] = A_OUT;
    start_run(20);
    check_caps("R9", '{2, 6});
  endtask

  task automatic t_bccl();
    clear_rom();
    rom[0] = a_ldi(-4); rom[1] = a_sta(1); rom[2] = a_ldi(1); rom[3] = a_sta(2);
    rom[4] = A_JMP; rom[5] = 8'hA0;
    rom[8'hA0] = a_lda(1); rom[8'hA1] = A_OUT; rom[8'hA2] = a_add(2);
    rom[8'hA3] = a_sta(1); rom[8'hA4] = A_BCCL; rom[8'hA5] = 8'hA0;
    rom[8'hA6] = A_OUT; rom[8'hA7] = a_bcc(2); rom[8'hA8] = a_ldi(1);
    rom[8'hA9] = A_OUT;
    start_run(60);
    // R8 taken backward while carry clear, falls through on carry and clears it
    check_caps("R8", '{252, 253, 254, 255, 0, 0});
  endtask

  task automatic t_undef();
    clear_rom();
    rom[0] = a_ldi(12); rom[1] = 8'h60; rom[2] = 8'h7F; rom[3] = 8'h5C;
    rom[4] = 8'h5F;     rom[5] = A_OUT;
    start_run(6);
    check_eq("R10", "pmem_addr after no-ops", int'(pmem_addr), 6);
    check_eq("R6", "out_valid after OUT edge", int'(out_valid), 1);
    check_eq("R10", "accumulator through no-ops", int'(out_data), 12);
    check_eq("R11", "count after six single-byte", int'(instr_count), 6);
    @(negedge clk);
    check_eq("R6", "strobe lasts one cycle", int'(out_valid), 0);
  endtask

  task automatic t_count();
    clear_rom();
    rom[0] = a_ldi(1); rom[1] = a_ldi(2); rom[2] = a_ldi(3); rom[3] = a_ldi(4);
    rom[4] = A_JMP; rom[5] = 8'h06; rom[6] = 8'h80;
    start_run(8);
    check_eq("R11", "count with two-byte jump", int'(instr_count), 7);
    check_eq("R7", "self branch holds address", int'(pmem_addr), 6);
    check_eq("R1", "no output strobe", ncap, 0);
  endtask

  task automatic t_fib();
    clear_rom();
    rom[0] = a_ldi(0); rom[1] = a_sta(0); rom[2] = a_ldi(1); rom[3] = a_sta(1);
    rom[4] = a_lda(1); rom[5] = a_sta(2); rom[6] = a_add(0); rom[7] = a_sta(1);
    rom[8] = a_lda(2); rom[9] = a_sta(0); rom[10] = A_OUT; rom[11] = a_bcc(-7);
    rom[12] = a_bcc(0);
    start_run(200);
    // R7 backward short branch until ADD carry ends the series
    check_caps("R7", '{1, 1, 2, 3, 5, 8, 13, 21, 34, 55, 89, 144, 233});
    check_eq("R7", "idle address", int'(pmem_addr), 12);
  endtask

  initial begin
    #1_500_000;
    failures = failures + 1;
    checks   = checks + 1;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks   = 0;
    failures = 0;
    ncap     = 0;
    rst      = 1'b1;
    clear_rom();
    t_reset();
    t_ldi_out();
    t_regs();
    t_add_carry();
    t_neg();
    t_jmp();
    t_bccl();
    t_undef();
    t_count();
    t_fib();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule